// File: doc/BRIEF.md
# Audio clock divider and sync monitor

This block turns a single master clock into the timing enables that a sampling audio front end needs. The master clock runs at either 256 or 384 times the frame rate, chosen by a mode input. The block delivers an internal 256-per-frame enable and a 128-per-frame sample enable. When it acts as the bus master, it also drives a bit clock at 128 periods per frame and a frame-sync clock at 2 periods per frame. All of them run in the master-clock domain.

The block also watches the external frame clock. The first rising frame edge after reset fixes the frame origin. Every later rising edge must fall within one master cycle of that origin. If an edge lands outside that window, or no edge arrives at all, the block raises its own resynchronising reset and silences every timing output. It then acquires a fresh origin. Outputs resume only after two consecutive frames have lined up.

States: `S_ACQ` waits for a rising frame edge. `S_VERIFY` counts aligned frames. `S_LOCK` is normal running. The transitions are:
- acquire: `S_ACQ`→`S_VERIFY` on any rising edge.
- confirm: `S_VERIFY`→`S_LOCK` on the second aligned edge.
- slip: `S_VERIFY`/`S_LOCK`→`S_ACQ` on a phase error.

Top module: `acd_clk_sync`

N is the frame length in master cycles: 256 when `ratio_hi`=0 and 384 when `ratio_hi`=1. Slot k is the master cycle that ends on the k-th rising clock edge after the edge that sampled the acquiring frame edge; that acquiring cycle is slot 0, and k is counted modulo N. A frame edge "in slot k" is one sampled at the clock edge that ends slot k.

## Requirements
- R1: With `ratio_hi`=0 and the block locked, `en_256` is high in every master cycle.
- R2: With `ratio_hi`=1 and the block locked, `en_256` is high in slot s exactly when s mod 3 is not 2, which gives 256 pulses per 384-cycle frame.
- R3: `en_128` is high exactly on those `en_256` cycles where the number of earlier `en_256` pulses in the frame is odd, which gives 128 per frame.
- R4: With `master_mode`=1 and the block locked, `bclk_out` equals bit 0 of that earlier-pulse count (128 periods per frame). `fsync_out` equals bit 6 of the count, so it is high for 64 of every 128 counts (2 periods per frame, 50% duty).
- R5: While `rst_n` is low or `sync_rst` is high, `en_256`, `en_128`, `bclk_out` and `fsync_out` are all low. Frame-clock activity while `rst_n` is low has no effect.
- R6: While verifying or locked, each of the following is a phase error:
  - a rising frame edge in any slot other than N-1, 0 or 1;
  - no rising frame edge in slots N-1, 0 or 1 by the end of slot 2.

  A phase error sets `sync_err` high for exactly the one following cycle, and `sync_rst` is high in that cycle.
- R7: After reset or a phase error, `sync_rst` stays high. The next rising frame edge becomes slot 0 of a new origin. `sync_rst` falls in the cycle after the second following aligned edge.
- R8: With `master_mode`=0, `bclk_out` and `fsync_out` stay low.
- R9: A frame edge in slot N-1 or slot 1 is accepted and does not move the origin, so all outputs keep the phase they had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 or 384 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_hi | input | 1 | 0: master clock is 256 per frame; 1: 384 per frame |
| master_mode | input | 1 | 1: drive bit clock and frame sync |
| lrck_in | input | 1 | External frame clock, synchronous to `clk` |
| en_256 | output | 1 | Internal 256-per-frame enable |
| en_128 | output | 1 | Sample enable, 128 per frame |
| bclk_out | output | 1 | Bit clock, 128 periods per frame |
| fsync_out | output | 1 | Frame sync, 2 periods per frame |
| sync_rst | output | 1 | Automatic resynchronising reset, high until locked |
| sync_err | output | 1 | One-cycle pulse after a phase error |

## Verification
Two error checks can both fire at the end of slot 2: the out-of-window edge check and the missing-edge check. The bench provokes this by delaying one frame edge by two cycles, so both checks trip on the same clock edge. It accepts the result only if exactly one `sync_err` pulse appears and the reacquired origin sits on the next edge. A second case places edges in slots N-1 and 1, next to the counter wrap. Every enable and clock output is compared cycle by cycle against the unchanged phase, which shows that a tolerated edge never moves the origin.

// File: rtl/acd_pkg.sv
package acd_pkg;
    typedef enum logic [1:0] {
        S_ACQ    = 2'd0,
        S_VERIFY = 2'd1,
        S_LOCK   = 2'd2
    } sync_state_e;
endpackage

// File: rtl/acd_frame_timer.sv
// Frame slot counter plus the two-of-three tick pattern for the 384 ratio.
module acd_frame_timer #(
    parameter int TICKS_PER_FRAME = 256,
    localparam int SLOTS_HI = TICKS_PER_FRAME * 3 / 2,
    localparam int SW = $clog2(SLOTS_HI),
    localparam int TW = $clog2(TICKS_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ratio_hi,
    input  logic          align,
    output logic [SW-1:0] slot,
    output logic [SW-1:0] slot_last,
    output logic          tick,
    output logic [TW-1:0] tcnt
);
    logic [1:0] ph3;
    logic       wrap;

    assign slot_last = ratio_hi ? SW'(SLOTS_HI - 1) : SW'(TICKS_PER_FRAME - 1);
    assign wrap      = (slot == slot_last);
    assign tick      = !ratio_hi || (ph3 != 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
            ph3  <= 2'd0;
            tcnt <= '0;
        end else if (align) begin
            // the sampling cycle was slot 0 and held a tick
            slot <= SW'(1);
            ph3  <= 2'd1;
            tcnt <= TW'(1);
        end else if (wrap) begin
            slot <= '0;
            ph3  <= 2'd0;
            tcnt <= '0;
        end else begin
            slot <= slot + SW'(1);
            ph3  <= (ph3 == 2'd2) ? 2'd0 : ph3 + 2'd1;
            tcnt <= tcnt + TW'(tick);
        end
    end
endmodule

// File: rtl/acd_phase_check.sv
// Frame-clock edge detector and slot-window checker.
module acd_phase_check #(
    parameter int SW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lrck_in,
    input  logic [SW-1:0] slot,
    input  logic [SW-1:0] slot_last,
    input  logic          armed,
    input  logic          align,
    output logic          rise,
    output logic          edge_ok,
    output logic          phase_err
);
    logic lrck_q;
    logic hit;
    logic in_win;
    logic late_slot;

    assign rise      = lrck_in && !lrck_q;
    assign in_win    = (slot == '0) || (slot == SW'(1)) || (slot == slot_last);
    assign late_slot = (slot == SW'(2));
    assign edge_ok   = rise && in_win;
    assign phase_err = armed && ((rise && !in_win) || (late_slot && !hit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrck_q <= 1'b1;
            hit    <= 1'b0;
        end else begin
            lrck_q <= lrck_in;
            if (align)
                hit <= 1'b1;
            else if (late_slot)
                hit <= 1'b0;
            else if (edge_ok)
                hit <= 1'b1;
        end
    end
endmodule

// File: rtl/acd_sync_fsm.sv
// Acquire / verify / lock sequencing of the resynchronising reset.
module acd_sync_fsm
    import acd_pkg::*;
#(
    parameter int LOCK_FRAMES = 2,
    localparam int GW = $clog2(LOCK_FRAMES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic edge_ok,
    input  logic phase_err,
    output logic armed,
    output logic align,
    output logic locked,
    output logic sync_err
);
    sync_state_e   state, nxt;
    logic [GW-1:0] good, good_nxt;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_ACQ;
            good  <= '0;
            err_q <= 1'b0;
        end else begin
            state <= nxt;
            good  <= good_nxt;
            err_q <= phase_err;
        end
    end

    always_comb begin
        nxt      = state;
        good_nxt = good;
        unique case (state)
            S_ACQ: begin
                if (rise) begin
                    nxt      = S_VERIFY;
                    good_nxt = '0;
                end
            end
            S_VERIFY: begin
                if (phase_err)
                    nxt = S_ACQ;
                else if (edge_ok) begin
                    if (good == GW'(LOCK_FRAMES - 1))
                        nxt = S_LOCK;
                    else
                        good_nxt = good + GW'(1);
                end
            end
            S_LOCK: begin
                if (phase_err)
                    nxt = S_ACQ;
            end
            default: nxt = S_ACQ;
        endcase
    end

    always_comb begin
        armed    = (state != S_ACQ);
        align    = (state == S_ACQ) && rise;
        locked   = (state == S_LOCK);
        sync_err = err_q;
    end
endmodule

// File: rtl/acd_clk_sync.sv
module acd_clk_sync #(
    parameter int TICKS_PER_FRAME = 256,
    parameter int LOCK_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_hi,
    input  logic master_mode,
    input  logic lrck_in,
    output logic en_256,
    output logic en_128,
    output logic bclk_out,
    output logic fsync_out,
    output logic sync_rst,
    output logic sync_err
);
    localparam int SLOTS_HI = TICKS_PER_FRAME * 3 / 2;
    localparam int SW = $clog2(SLOTS_HI);
    localparam int TW = $clog2(TICKS_PER_FRAME);

    logic [SW-1:0] slot, slot_last;
    logic [TW-1:0] tcnt;
    logic          tick, align, armed, locked;
    logic          rise, edge_ok, phase_err;

    acd_frame_timer #(.TICKS_PER_FRAME(TICKS_PER_FRAME)) u_timer (
        .clk(clk), .rst_n(rst_n), .ratio_hi(ratio_hi), .align(align),
        .slot(slot), .slot_last(slot_last), .tick(tick), .tcnt(tcnt)
    );

    acd_phase_check #(.SW(SW)) u_phase (
        .clk(clk), .rst_n(rst_n), .lrck_in(lrck_in), .slot(slot),
        .slot_last(slot_last), .armed(armed), .align(align),
        .rise(rise), .edge_ok(edge_ok), .phase_err(phase_err)
    );

    acd_sync_fsm #(.LOCK_FRAMES(LOCK_FRAMES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .edge_ok(edge_ok),
        .phase_err(phase_err), .armed(armed), .align(align),
        .locked(locked), .sync_err(sync_err)
    );

    assign en_256    = locked && tick;
    assign en_128    = locked && tick && tcnt[0];
    assign bclk_out  = locked && master_mode && tcnt[0];
    assign fsync_out = locked && master_mode && tcnt[TW-2];
    assign sync_rst  = !locked;
endmodule

// File: rtl/acd_clk_sync_checker.sv
module acd_clk_sync_checker (
    input logic clk,
    input logic rst_n,
    input logic ratio_hi,
    input logic master_mode,
    input logic en_256,
    input logic en_128,
    input logic bclk_out,
    input logic fsync_out,
    input logic sync_rst,
    input logic sync_err
);
    a_r5_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst |-> !(en_256 || en_128 || bclk_out || fsync_out));

    a_r3_sample_within_fast: assert property (@(posedge clk) disable iff (!rst_n)
        en_128 |-> en_256);

    a_r1_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!ratio_hi && !sync_rst) |-> en_256);

    a_r2_third_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_hi && $past(ratio_hi) && en_256 && $past(en_256)) |=> !en_256);

    a_r8_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!bclk_out && !fsync_out));

    a_r6_err_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> sync_rst);

    a_r4_fsync_on_even: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_out) |-> !bclk_out);
endmodule

bind acd_clk_sync acd_clk_sync_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ratio_hi(ratio_hi), .master_mode(master_mode),
    .en_256(en_256), .en_128(en_128), .bclk_out(bclk_out),
    .fsync_out(fsync_out), .sync_rst(sync_rst), .sync_err(sync_err)
);

// File: tb/acd_clk_sync_test.sv
module acd_clk_sync_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ratio_hi = 1'b0;
    logic master_mode = 1'b0;
    logic lrck_in = 1'b0;
    logic en_256, en_128, bclk_out, fsync_out, sync_rst, sync_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int nper = 256;
    int off_tab [0:15];
    bit has_edge [0:15];

    acd_clk_sync uut (
        .clk(clk), .rst_n(rst_n), .ratio_hi(ratio_hi), .master_mode(master_mode),
        .lrck_in(lrck_in), .en_256(en_256), .en_128(en_128), .bclk_out(bclk_out),
        .fsync_out(fsync_out), .sync_rst(sync_rst), .sync_err(sync_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // frame clock level sampled at the edge ending step j
    function automatic bit lr_at(input int j);
        int f;
        int r;
        f = j / nper;
        for (int g = f - 1; g <= f + 1; g++) begin
            if (g >= 0 && g < 16 && has_edge[g]) begin
                r = g * nper + off_tab[g];
                if (j >= r && j < r + nper / 2) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    // {en_256, en_128, bclk_out, fsync_out} for a locked block in slot m
    function automatic logic [3:0] exp_outs(input int m, input bit hi, input bit ms);
        int t;
        bit tk;
        if (hi) begin
            t  = (2 * (m / 3) + (m % 3)) % 256;
            tk = (m % 3) != 2;
        end else begin
            t  = m;
            tk = 1'b1;
        end
        return {tk, tk && t[0], ms && t[0], ms && t[6]};
    endfunction

    // kind 0: edge two slots late, 1: two slots early, 2: edge missing
    task automatic run_case(input bit hi, input bit ms, input int kind, input int b);
        int err_j, a2, end_j, m;
        bit lk, jit;
        logic [3:0] eo;
        string rq;
        @(negedge clk);
        rst_n = 1'b0;
        ratio_hi = hi;
        master_mode = ms;
        nper = hi ? 384 : 256;
        for (int i = 0; i < 6; i++) begin
            lrck_in = i[0];
            @(negedge clk);
            // R5: outputs silent in reset, frame clock toggling ignored
            chk(en_256 | en_128 | bclk_out | fsync_out, 1'b0, "R5", "reset outputs");
            chk(sync_rst, 1'b1, "R5", "reset sync_rst");
        end
        lrck_in = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(sync_rst, 1'b1, "R7", "idle sync_rst");
            chk(en_256, 1'b0, "R5", "idle en_256");
        end
        for (int f = 0; f < 16; f++) begin
            has_edge[f] = 1'b1;
            off_tab[f] = (f >= 7) ? b : 0;
        end
        off_tab[3] = 1;
        off_tab[4] = -1;
        if (kind == 0) off_tab[6] = 2;
        else if (kind == 1) off_tab[6] = -2;
        else has_edge[6] = 1'b0;
        err_j = (kind == 1) ? 6 * nper - 2 : 6 * nper + 2;
        a2    = 7 * nper + b;
        end_j = a2 + 3 * nper;
        for (int j = 0; j <= end_j; j++) begin
            lrck_in = lr_at(j);
            @(posedge clk);
            @(negedge clk);
            m = 0;
            if (j < 2 * nper) lk = 1'b0;
            else if (j < err_j) begin lk = 1'b1; m = (j + 1) % nper; end
            else if (j < a2 + 2 * nper) lk = 1'b0;
            else begin lk = 1'b1; m = (j - a2 + 1) % nper; end
            jit = (j >= 3 * nper - 1) && (j < 5 * nper);
            eo = lk ? exp_outs(m, hi, ms) : 4'b0000;
            chk(sync_rst, !lk, jit ? "R9" : "R7", "sync_rst");
            chk(sync_err, j == err_j, "R6", "sync_err");
            rq = !lk ? "R5" : (hi ? "R2" : "R1");
            chk(en_256, eo[3], rq, "en_256");
            chk(en_128, eo[2], lk ? "R3" : "R5", "en_128");
            rq = !lk ? "R5" : (ms ? "R4" : "R8");
            chk(bclk_out, eo[1], rq, "bclk_out");
            chk(fsync_out, eo[0], rq, "fsync_out");
        end
    endtask

    initial begin
        void'($urandom(32'd1729));
        run_case(1'b0, 1'b1, 0, $urandom_range(0, 80));
        run_case(1'b1, 1'b1, 1, $urandom_range(0, 120));
        run_case(1'b1, 1'b0, 2, $urandom_range(0, 120));
        run_case(1'b0, 1'b0, 2, 0);
        for (int r = 0; r < 2; r++)
            run_case(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, 2)), $urandom_range(0, 80));
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule